// File: doc/BRIEF.md
# Double-Write Cipher Control Register

This block holds the configuration word of a block-cipher engine: the chaining mode, the key length, the direction (encrypt or decrypt), a manual-start bit and a bit that forces the masking randomness to zero. A configuration change takes effect only when the same value is written twice in a row. A single corrupted or stray bus write therefore cannot change the engine's setup. When the two writes do not agree, the block raises a one-cycle recoverable error and drops the first write.

Every write is cleaned before it is stored or compared. The mode and key-length fields are one-hot, and any illegal encoding is replaced with a fixed safe setting. The 192-bit key length can be disabled at build time, in which case that encoding is also replaced. Writes are accepted only while the engine reports idle. A test input lets software raise the error output on demand.

Top module: `cipher_ctrl_shadow`

## Requirements
- R1: After reset, `rd_data_o` reads 0x240 (mode 0x20, key length 3'b100, all single-bit fields 0) and `upd_err_o` is 0. The layout is: direction in bit 0 (1 = decrypt), mode in bits 6:1, key length in bits 9:7, manual in bit 10 and force-zero-masks in bit 11. Bits above 11 read as 0.
- R2: An accepted write made while nothing is staged only stages the cleaned value. `rd_data_o` is unchanged after that write.
- R3: An accepted write whose cleaned value equals the staged value commits it. `rd_data_o` shows the new value from the cycle after that clock edge, and the staging copy is emptied. Idle cycles between the two writes are allowed.
- R4: An accepted write whose cleaned value differs from the staged value leaves `rd_data_o` unchanged. It drives `upd_err_o` high for exactly the next cycle and empties the staging copy, so the following write counts as a first write.
- R5: A mode field that is not exactly one-hot (0, or more than one bit set) is stored as 0x20 (NONE). The legal mode codes are 0x01, 0x02, 0x04, 0x08, 0x10 and 0x20. The compare in R3 and R4 uses cleaned values, so two different illegal modes still match.
- R6: A key-length field of 3'b000, or one with more than one bit set, is stored as 3'b100 (256-bit). The codes 3'b001 (128-bit) and 3'b010 (192-bit) are kept when legal.
- R7: With `Allow192` = 0, a key-length field of 3'b010 is stored as 3'b100. With `Allow192` = 1, it is kept.
- R8: A write made while `engine_idle_i` is 0 is ignored. It changes neither the committed value nor the staging copy.
- R9: A pulse on `err_test_i` drives `upd_err_o` high in the following cycle without touching the register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for one cycle |
| wr_data_i | input | 12 | Write data (control fields) |
| engine_idle_i | input | 1 | Engine idle; writes are accepted only when this is 1 |
| err_test_i | input | 1 | Raise the update error for test |
| rd_data_o | output | 32 | Committed, cleaned configuration |
| upd_err_o | output | 1 | Recoverable update-error pulse |

## Verification
Each result is due one clock edge after its stimulus. A write sampled at a rising edge shows up on `rd_data_o` right after that edge, and the error pulse for a mismatch or a test request is registered at the same edge. The bench drives each stimulus at a falling edge and checks the outputs at the next falling edge, so it always samples exactly one register stage later. The stimulus table checks `upd_err_o` on every row. This shows that the error is a single-cycle pulse and appears only on a mismatching second write.

// File: rtl/cipher_ctrl_pkg.sv
`timescale 1ns/1ps
package cipher_ctrl_pkg;
  localparam int MODE_W   = 6;
  localparam int KEYLEN_W = 3;
  localparam int CTRL_W   = 2 + MODE_W + KEYLEN_W + 1;

  localparam logic [MODE_W-1:0]   MODE_NONE = 6'h20;
  localparam logic [KEYLEN_W-1:0] KEY_256   = 3'b100;
  localparam logic [KEYLEN_W-1:0] KEY_192   = 3'b010;

  // bit 11 zero-mask, bit 10 manual, 9:7 key length, 6:1 mode, 0 direction
  typedef struct packed {
    logic                zero_mask;
    logic                manual;
    logic [KEYLEN_W-1:0] keylen;
    logic [MODE_W-1:0]   mode;
    logic                decrypt;
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = '{zero_mask: 1'b0, manual: 1'b0,
                                   keylen: KEY_256, mode: MODE_NONE,
                                   decrypt: 1'b0};

  function automatic logic [MODE_W-1:0] clean_mode(input logic [MODE_W-1:0] m);
    return ($countones(m) == 1) ? m : MODE_NONE;
  endfunction

  function automatic logic [KEYLEN_W-1:0] clean_keylen(
      input logic [KEYLEN_W-1:0] k, input bit allow192);
    if ($countones(k) != 1)            return KEY_256;
    if (!allow192 && (k == KEY_192))   return KEY_256;
    return k;
  endfunction
endpackage

// File: rtl/cipher_ctrl_clean.sv
`timescale 1ns/1ps
module cipher_ctrl_clean
  import cipher_ctrl_pkg::*;
#(
  parameter bit Allow192 = 1'b1
) (
  input  logic [CTRL_W-1:0] raw_i,
  output ctrl_t             clean_o
);
  ctrl_t raw;
  assign raw = ctrl_t'(raw_i);

  always_comb begin
    clean_o        = raw;
    clean_o.mode   = clean_mode(raw.mode);
    clean_o.keylen = clean_keylen(raw.keylen, Allow192);
  end

  always_comb begin
    a_r5_mode_onehot: assert ($countones(clean_o.mode) == 1);
    a_r6_keylen_onehot: assert ($countones(clean_o.keylen) == 1);
  end
endmodule

// File: rtl/cipher_ctrl_stage.sv
`timescale 1ns/1ps
module cipher_ctrl_stage
  import cipher_ctrl_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  accept_i,
  input  ctrl_t cand_i,
  output logic  staged_o,
  output logic  match_o,
  output logic  mismatch_o
);
  ctrl_t stage_q;
  logic  staged_q;

  assign match_o    = accept_i && staged_q && (cand_i == stage_q);
  assign mismatch_o = accept_i && staged_q && (cand_i != stage_q);
  assign staged_o   = staged_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      staged_q <= 1'b0;
      stage_q  <= CTRL_RESET;
    end else if (accept_i) begin
      staged_q <= !staged_q;
      if (!staged_q) stage_q <= cand_i;
    end
  end

  a_r4_second_write_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && staged_q) |=> !staged_q);
  a_r2_first_write_stages: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && !staged_q) |=> staged_q);
endmodule

// File: rtl/cipher_ctrl_shadow.sv
`timescale 1ns/1ps
module cipher_ctrl_shadow
  import cipher_ctrl_pkg::*;
#(
  parameter bit Allow192  = 1'b1,
  parameter int BusWidth  = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [CTRL_W-1:0]   wr_data_i,
  input  logic                engine_idle_i,
  input  logic                err_test_i,
  output logic [BusWidth-1:0] rd_data_o,
  output logic                upd_err_o
);
  localparam int PadW = BusWidth - CTRL_W;

  ctrl_t cand, committed_q;
  logic  wr_accept, staged, wr_match, wr_mismatch, err_q;

  assign wr_accept = wr_en_i && engine_idle_i;

  cipher_ctrl_clean #(.Allow192(Allow192)) u_clean (
    .raw_i   (wr_data_i),
    .clean_o (cand)
  );

  cipher_ctrl_stage u_stage (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (wr_accept),
    .cand_i     (cand),
    .staged_o   (staged),
    .match_o    (wr_match),
    .mismatch_o (wr_mismatch)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      committed_q <= CTRL_RESET;
      err_q       <= 1'b0;
    end else begin
      if (wr_match) committed_q <= cand;
      err_q <= wr_mismatch || err_test_i;
    end
  end

  assign rd_data_o = {{PadW{1'b0}}, committed_q};
  assign upd_err_o = err_q;

  a_r8_busy_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !engine_idle_i) |=> ($stable(committed_q) && $stable(staged)));
  a_r2_first_write_no_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_accept && !staged) |=> $stable(rd_data_o));
  a_r4_mismatch_raises_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mismatch |=> (upd_err_o && $stable(rd_data_o)));
  a_r9_test_raises_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_test_i |=> upd_err_o);
  a_r4_err_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_mismatch && !err_test_i) |=> !upd_err_o);
endmodule

// File: tb/test_cipher_ctrl_shadow.sv
`timescale 1ns/1ps
module test_cipher_ctrl_shadow;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] wr_data = '0;
  logic        idle = 1'b1;
  logic        err_test = 1'b0;
  logic [31:0] rd_a, rd_b;
  logic        err_a, err_b;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  cipher_ctrl_shadow i_cipher_ctrl_shadow (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .engine_idle_i(idle), .err_test_i(err_test), .rd_data_o(rd_a), .upd_err_o(err_a));

  cipher_ctrl_shadow #(.Allow192(1'b0)) i_cipher_ctrl_shadow_no192 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .engine_idle_i(idle), .err_test_i(err_test), .rd_data_o(rd_b), .upd_err_o(err_b));

  // {idle, wr_en, data, expected read after edge, expected error after edge}
  typedef struct packed {
    logic        idle;
    logic        we;
    logic [11:0] data;
    logic [31:0] exp_rd;
    logic        exp_err;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 12'h082, 32'h240, 1'b0},  // R2 first write only stages
    '{1'b1, 1'b1, 12'h082, 32'h082, 1'b0},  // R3 commit
    '{1'b1, 1'b1, 12'h505, 32'h082, 1'b0},  // R2
    '{1'b1, 1'b0, 12'h000, 32'h082, 1'b0},  // R3 gap between writes
    '{1'b1, 1'b1, 12'h505, 32'h505, 1'b0},  // R3 commit after gap
    '{1'b1, 1'b1, 12'hA20, 32'h505, 1'b0},  // R2
    '{1'b1, 1'b1, 12'h082, 32'h505, 1'b1},  // R4 mismatch
    '{1'b1, 1'b1, 12'hA20, 32'h505, 1'b0},  // R4 stage emptied: first write
    '{1'b1, 1'b1, 12'hA20, 32'hA20, 1'b0},  // R3
    '{1'b1, 1'b1, 12'h086, 32'hA20, 1'b0},  // R5 two-bit mode
    '{1'b1, 1'b1, 12'h086, 32'h0C0, 1'b0},  // R5 stored as NONE
    '{1'b1, 1'b1, 12'h010, 32'h0C0, 1'b0},  // R6 key 000
    '{1'b1, 1'b1, 12'h010, 32'h210, 1'b0},  // R6 stored as 256
    '{1'b1, 1'b1, 12'h188, 32'h210, 1'b0},  // R6 key 011
    '{1'b1, 1'b1, 12'h188, 32'h208, 1'b0},  // R6 stored as 256
    '{1'b1, 1'b1, 12'h082, 32'h208, 1'b0},  // R8 first write
    '{1'b0, 1'b1, 12'h505, 32'h208, 1'b0},  // R8 busy write ignored
    '{1'b1, 1'b1, 12'h082, 32'h082, 1'b0},  // R8 staging kept, commits
    '{1'b0, 1'b1, 12'h505, 32'h082, 1'b0},  // R8 busy, nothing staged
    '{1'b1, 1'b1, 12'h505, 32'h082, 1'b0},  // R8 counts as first write
    '{1'b1, 1'b1, 12'h505, 32'h505, 1'b0},  // R3
    '{1'b1, 1'b1, 12'h080, 32'h505, 1'b0},  // R5 mode zero
    '{1'b1, 1'b1, 12'h086, 32'h0C0, 1'b0}   // R5 cleaned values match
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic i, input logic we, input logic [11:0] d, input logic t);
    idle = i; wr_en = we; wr_data = d; err_test = t;
    @(negedge clk);
    wr_en = 1'b0; err_test = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset read", rd_a, 32'h240);
    check("R1 reset error", {31'b0, err_a}, 32'h0);
    check("R1 reset read no192", rd_b, 32'h240);

    for (int k = 0; k < NV; k++) begin
      step(VECS[k].idle, VECS[k].we, VECS[k].data, 1'b0);
      check($sformatf("R2/R3/R4/R5/R6/R8 row %0d read", k), rd_a, VECS[k].exp_rd);
      check($sformatf("R4 row %0d error", k), {31'b0, err_a}, {31'b0, VECS[k].exp_err});
    end

    // R7: key 010 with ECB, written twice
    step(1'b1, 1'b1, 12'h102, 1'b0);
    step(1'b1, 1'b1, 12'h102, 1'b0);
    check("R7 192 kept when allowed", rd_a, 32'h102);
    check("R7 192 replaced when disabled", rd_b, 32'h202);

    // R9: test pulse gives one error cycle, contents untouched
    step(1'b1, 1'b0, 12'h000, 1'b1);
    check("R9 test error", {31'b0, err_a}, 32'h1);
    check("R9 contents kept", rd_a, 32'h102);
    step(1'b1, 1'b0, 12'h000, 1'b0);
    check("R9 error is one cycle", {31'b0, err_a}, 32'h0);

    // R4: error lasts only one cycle after a mismatch
    step(1'b1, 1'b1, 12'h082, 1'b0);
    step(1'b1, 1'b1, 12'h505, 1'b0);
    check("R4 mismatch error", {31'b0, err_a}, 32'h1);
    step(1'b1, 1'b0, 12'h000, 1'b0);
    check("R4 error drops", {31'b0, err_a}, 32'h0);
    check("R4 no commit", rd_a, 32'h102);

    // R1: reset mid-stream restores defaults
    step(1'b1, 1'b1, 12'hA20, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, 1'b1, 12'hA20, 1'b0);
    check("R1 reset empties staging", rd_a, 32'h240);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule